// File: doc/BRIEF.md
# DRAM Bank State Tracker

This block follows the command stream that a memory controller sends to an eight-bank SDRAM device and keeps its own copy of each bank's condition. A bank is in one of three conditions: idle, open (a row is active), or precharging. A precharge can come from an explicit precharge command or from a read or write that carries auto precharge. A precharging bank counts down a recovery window of `TRP_CYC` clock cycles and then returns to idle. The controller can use the per-bank flags to schedule commands, and the violation strobe to catch commands the device would not accept.

Each cycle the block takes one decoded command together with the all-banks address bit and the bank number. Bank flags and the violation strobe are registered. They reflect a command one clock edge after it is presented. An illegal command raises the strobe for one cycle and does not change any bank's open/idle condition. Recovery counters that are already running keep counting.

Top module: `bank_tracker`

## Requirements
- R1: After reset every bank is idle and not precharging, and `viol_o` is low.
- R2: An ACTIVATE (code 1) to an idle bank makes that bank open after the next clock edge, without a violation.
- R3: An ACTIVATE to a bank that is open or precharging pulses `viol_o` and leaves every bank's open flag unchanged.
- R4: A PRECHARGE (code 6) with `a10_i` low to an open bank closes only the bank selected by `ba_i`. That bank shows precharging for exactly `TRP_CYC` cycles and then becomes idle.
- R5: A PRECHARGE with `a10_i` high moves every open bank to precharging regardless of `ba_i`. Idle banks stay idle, and no violation is raised.
- R6: A PRECHARGE to an idle bank changes nothing and raises no violation.
- R7: A PRECHARGE to a bank that is already precharging restarts its recovery, so that it stays precharging for `TRP_CYC` cycles counted from the latest PRECHARGE.
- R8: A READ (code 2) or WRITE (code 3) to an open bank is accepted with no state change. A READ, WRITE, READ with auto precharge (code 4) or WRITE with auto precharge (code 5) to a bank that is not open pulses `viol_o` and changes no state.
- R9: A READ or WRITE with auto precharge to an open bank starts that bank's `TRP_CYC` recovery. While it runs, reads and writes to other open banks are accepted.
- R10: A REFRESH (code 7) is accepted only when no bank is open or precharging. Otherwise `viol_o` pulses. `a10_i` and `ba_i` have no effect on a REFRESH.
- R11: `viol_o` is high for one cycle per illegal command. It is low after a NOP (code 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 3 | Command code: 0 NOP, 1 ACTIVATE, 2 READ, 3 WRITE, 4 READ+AP, 5 WRITE+AP, 6 PRECHARGE, 7 REFRESH |
| a10_i | input | 1 | All-banks select for PRECHARGE |
| ba_i | input | 3 | Bank number |
| bank_open_o | output | 8 | One bit per bank, high while a row is open |
| bank_pre_o | output | 8 | One bit per bank, high during precharge recovery |
| viol_o | output | 1 | One-cycle strobe for an illegal command |

## Verification
The assertions assume that exactly one command is presented on every clock edge. They also assume that `cmd_i`, `a10_i` and `ba_i` are always known values, with NOP standing for "no command". Under these assumptions, the check that an illegal ACTIVATE leaves the open flags unchanged is a meaningful one-cycle comparison. The stimulus meets the assumptions by having a single driver task that sets all three inputs on each falling edge. It covers directed sequences and a pseudo-random command run, and every bank number stays inside the eight-bank range.

// File: rtl/bank_trk_pkg.sv
package bank_trk_pkg;

    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_ACT  = 3'd1,
        CMD_RD   = 3'd2,
        CMD_WR   = 3'd3,
        CMD_RDAP = 3'd4,
        CMD_WRAP = 3'd5,
        CMD_PRE  = 3'd6,
        CMD_REF  = 3'd7
    } cmd_e;

    typedef enum logic [1:0] {
        BK_IDLE = 2'd0,
        BK_OPEN = 2'd1,
        BK_PRE  = 2'd2
    } bank_st_e;

endpackage

// File: rtl/bank_cmd_check.sv
module bank_cmd_check
    import bank_trk_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int BA_W      = 3
) (
    input  logic [2:0]           cmd,
    input  logic                 a10,
    input  logic [BA_W-1:0]      ba,
    input  logic [NUM_BANKS-1:0] open_vec,
    input  logic [NUM_BANKS-1:0] pre_vec,
    output logic [NUM_BANKS-1:0] act_vec,
    output logic [NUM_BANKS-1:0] close_vec,
    output logic                 illegal
);

    logic [NUM_BANKS-1:0] sel;
    logic                 tgt_open;
    logic                 tgt_busy;

    always_comb begin
        sel       = {{(NUM_BANKS-1){1'b0}}, 1'b1} << ba;
        tgt_open  = |(open_vec & sel);
        tgt_busy  = |((open_vec | pre_vec) & sel);
        act_vec   = '0;
        close_vec = '0;
        illegal   = 1'b0;
        case (cmd_e'(cmd))
            CMD_ACT: begin
                if (tgt_busy) illegal = 1'b1;
                else          act_vec = sel;
            end
            CMD_RD, CMD_WR: begin
                illegal = !tgt_open;
            end
            CMD_RDAP, CMD_WRAP: begin
                if (!tgt_open) illegal   = 1'b1;
                else           close_vec = sel;
            end
            CMD_PRE: begin
                close_vec = a10 ? {NUM_BANKS{1'b1}} : sel;
            end
            CMD_REF: begin
                illegal = |(open_vec | pre_vec);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/bank_fsm.sv
module bank_fsm
    import bank_trk_pkg::*;
#(
    parameter int TRP_CYC = 6,
    localparam int CNT_W  = (TRP_CYC > 1) ? $clog2(TRP_CYC) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act,
    input  logic close,
    output logic is_open,
    output logic is_pre
);

    typedef struct packed {
        bank_st_e         st;
        logic [CNT_W-1:0] cnt;
    } bank_reg_t;

    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(TRP_CYC - 1);

    bank_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (close && (r_q.st != BK_IDLE)) begin
            r_d.st  = BK_PRE;
            r_d.cnt = RELOAD;
        end else if (act) begin
            r_d.st  = BK_OPEN;
        end else if (r_q.st == BK_PRE) begin
            if (r_q.cnt == '0) r_d.st  = BK_IDLE;
            else               r_d.cnt = r_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st  <= BK_IDLE;
            r_q.cnt <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign is_open = (r_q.st == BK_OPEN);
    assign is_pre  = (r_q.st == BK_PRE);

endmodule

// File: rtl/bank_tracker.sv
module bank_tracker
    import bank_trk_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int TRP_CYC   = 6,
    localparam int BA_W     = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           cmd_i,
    input  logic                 a10_i,
    input  logic [BA_W-1:0]      ba_i,
    output logic [NUM_BANKS-1:0] bank_open_o,
    output logic [NUM_BANKS-1:0] bank_pre_o,
    output logic                 viol_o
);

    typedef struct packed {
        logic viol;
    } top_reg_t;

    logic [NUM_BANKS-1:0] act_vec;
    logic [NUM_BANKS-1:0] close_vec;
    logic                 illegal;
    top_reg_t             t_d, t_q;

    bank_cmd_check #(
        .NUM_BANKS(NUM_BANKS),
        .BA_W     (BA_W)
    ) u_check (
        .cmd      (cmd_i),
        .a10      (a10_i),
        .ba       (ba_i),
        .open_vec (bank_open_o),
        .pre_vec  (bank_pre_o),
        .act_vec  (act_vec),
        .close_vec(close_vec),
        .illegal  (illegal)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        bank_fsm #(
            .TRP_CYC(TRP_CYC)
        ) u_fsm (
            .clk    (clk),
            .rst_n  (rst_n),
            .act    (act_vec[b]),
            .close  (close_vec[b]),
            .is_open(bank_open_o[b]),
            .is_pre (bank_pre_o[b])
        );
    end

    always_comb begin
        t_d      = t_q;
        t_d.viol = illegal;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q.viol <= 1'b0;
        else        t_q      <= t_d;
    end

    assign viol_o = t_q.viol;

endmodule

// File: rtl/bank_tracker_chk.sv
module bank_tracker_chk
    import bank_trk_pkg::*;
#(
    parameter int NUM_BANKS = 8,
    parameter int BA_W      = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [2:0]           cmd_i,
    input logic                 a10_i,
    input logic [BA_W-1:0]      ba_i,
    input logic [NUM_BANKS-1:0] bank_open_o,
    input logic [NUM_BANKS-1:0] bank_pre_o,
    input logic                 viol_o
);

    // R4
    open_pre_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_open_o & bank_pre_o) == '0);

    // R2
    act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_ACT && !bank_open_o[ba_i] && !bank_pre_o[ba_i])
        |=> (bank_open_o[$past(ba_i)] && !viol_o));

    // R3
    act_busy_viol_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_ACT && (bank_open_o[ba_i] || bank_pre_o[ba_i]))
        |=> (viol_o && $stable(bank_open_o)));

    // R4
    single_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_PRE && !a10_i && bank_open_o[ba_i])
        |=> (bank_pre_o[$past(ba_i)] && !bank_open_o[$past(ba_i)]));

    // R5
    all_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_PRE && a10_i) |=> (bank_open_o == '0 && !viol_o));

    // R6
    idle_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_PRE && !a10_i && !bank_open_o[ba_i] && !bank_pre_o[ba_i])
        |=> (!viol_o && !bank_pre_o[$past(ba_i)] && !bank_open_o[$past(ba_i)]));

    // R8
    rw_closed_viol_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_i == CMD_RD || cmd_i == CMD_WR) && !bank_open_o[ba_i]) |=> viol_o);

    // R10
    ref_busy_viol_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_REF && ((bank_open_o | bank_pre_o) != '0)) |=> viol_o);

    // R11
    nop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_NOP) |=> !viol_o);

endmodule

bind bank_tracker bank_tracker_chk #(
    .NUM_BANKS(NUM_BANKS),
    .BA_W     (BA_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_i      (cmd_i),
    .a10_i      (a10_i),
    .ba_i       (ba_i),
    .bank_open_o(bank_open_o),
    .bank_pre_o (bank_pre_o),
    .viol_o     (viol_o)
);

// File: tb/bank_tracker_test.sv
module bank_tracker_test;

    localparam int TRP = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cmd_i = 3'd0;
    logic       a10_i = 1'b0;
    logic [2:0] ba_i = 3'd0;
    logic [7:0] bank_open_o;
    logic [7:0] bank_pre_o;
    logic       viol_o;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [7:0] open_v;
        logic [7:0] pre_v;
        logic       viol;
        string      tag;
    } exp_t;

    exp_t exp_q[$];

    logic [7:0] m_open = '0;
    logic [7:0] m_pre  = '0;
    int         m_cnt[8];

    always #4 clk = ~clk;

    bank_tracker #(.NUM_BANKS(8), .TRP_CYC(TRP)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_i      (cmd_i),
        .a10_i      (a10_i),
        .ba_i       (ba_i),
        .bank_open_o(bank_open_o),
        .bank_pre_o (bank_pre_o),
        .viol_o     (viol_o)
    );

    task automatic model_step(input logic [2:0] c, input logic a10, input logic [2:0] b,
                              output logic v, output string tag);
        logic [7:0] cl = '0;
        logic [7:0] ac = '0;
        v = 1'b0;
        case (c)
            3'd1: if (m_open[b] || m_pre[b]) begin v = 1'b1; tag = "R3"; end
                  else begin ac[b] = 1'b1; tag = "R2"; end
            3'd2, 3'd3: begin tag = "R8"; v = !m_open[b]; end
            3'd4, 3'd5: if (!m_open[b]) begin v = 1'b1; tag = "R8"; end
                        else begin cl[b] = 1'b1; tag = "R9"; end
            3'd6: if (a10) begin cl = '1; tag = "R5"; end
                  else begin
                      cl[b] = 1'b1;
                      tag = m_pre[b] ? "R7" : (m_open[b] ? "R4" : "R6");
                  end
            3'd7: begin tag = "R10"; v = |(m_open | m_pre); end
            default: tag = "R11";
        endcase
        for (int i = 0; i < 8; i++) begin
            if (cl[i] && (m_open[i] || m_pre[i])) begin
                m_open[i] = 1'b0; m_pre[i] = 1'b1; m_cnt[i] = TRP - 1;
            end else if (ac[i]) begin
                m_open[i] = 1'b1;
            end else if (m_pre[i]) begin
                if (m_cnt[i] == 0) m_pre[i] = 1'b0;
                else               m_cnt[i]--;
            end
        end
    endtask

    task automatic drive(input logic [2:0] c, input logic a10, input logic [2:0] b);
        exp_t  e;
        logic  v;
        string t;
        @(negedge clk);
        cmd_i = c; a10_i = a10; ba_i = b;
        model_step(c, a10, b, v, t);
        e.open_v = m_open; e.pre_v = m_pre; e.viol = v; e.tag = t;
        exp_q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(3'd0, 1'b0, 3'd0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (bank_open_o !== e.open_v || bank_pre_o !== e.pre_v || viol_o !== e.viol) begin
                    errors++;
                    $display("FAIL %s: open=%b pre=%b viol=%b expected open=%b pre=%b viol=%b",
                             e.tag, bank_open_o, bank_pre_o, viol_o, e.open_v, e.pre_v, e.viol);
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) m_cnt[i] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        checks++;
        if (bank_open_o !== 8'h00 || bank_pre_o !== 8'h00 || viol_o !== 1'b0) begin
            errors++;
            $display("FAIL R1: open=%b pre=%b viol=%b expected all zero",
                     bank_open_o, bank_pre_o, viol_o);
        end
        // R2 activations
        drive(3'd1, 1'b0, 3'd0);
        drive(3'd1, 1'b0, 3'd3);
        // R3 activate of an open bank
        drive(3'd1, 1'b0, 3'd0);
        // R8 reads and writes
        drive(3'd2, 1'b0, 3'd0);
        drive(3'd3, 1'b0, 3'd5);
        drive(3'd4, 1'b0, 3'd6);
        // R4 single precharge, then R7 restart part way
        drive(3'd6, 1'b0, 3'd3);
        idle(2);
        drive(3'd6, 1'b0, 3'd3);
        // R3 activate of a precharging bank
        drive(3'd1, 1'b0, 3'd3);
        idle(TRP + 1);
        // R6 precharge of an idle bank
        drive(3'd6, 1'b0, 3'd6);
        // R9 auto precharge with traffic to other banks
        drive(3'd1, 1'b0, 3'd1);
        drive(3'd1, 1'b0, 3'd2);
        drive(3'd4, 1'b0, 3'd1);
        drive(3'd3, 1'b0, 3'd2);
        drive(3'd2, 1'b0, 3'd0);
        drive(3'd5, 1'b0, 3'd2);
        // R10 refresh while busy
        drive(3'd7, 1'b1, 3'd4);
        // R5 all-bank precharge naming an idle bank
        drive(3'd6, 1'b1, 3'd7);
        idle(TRP + 2);
        // R10 refresh with all idle, fields arbitrary
        drive(3'd7, 1'b1, 3'd5);
        drive(3'd7, 1'b0, 3'd2);
        // R11 strobe drops after NOP
        drive(3'd2, 1'b0, 3'd4);
        idle(1);
        // mixed pseudo-random traffic
        for (int i = 0; i < 400; i++) begin
            logic [2:0] c;
            c = 3'($urandom_range(0, 7));
            if (c == 3'd7 && ($urandom_range(0, 3) != 0)) c = 3'd1;
            drive(c, 1'($urandom_range(0, 5) == 0), 3'($urandom_range(0, 7)));
        end
        idle(2);
        @(posedge clk);
        #3;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule